// File: doc/BRIEF.md
# External Interrupt Request Sampler

This block turns one active-low external interrupt pin into the request flag that an interrupt controller polls. The pin is first brought into the clock domain through a short flop chain. It is then looked at only when the machine-cycle strobe is high, once every twelve oscillator periods in the intended system. A mode input selects one of two detection schemes. In level mode the flag copies the inverted pin at every sample. In edge mode the flag is set by a high sample followed by a low sample, and stays set until the controller acknowledges the request.

The controller pulses `ack_i` when it vectors to the service routine. That pulse clears the flag only in edge mode. In level mode the flag follows the pin, so a request still held low raises the interrupt again. Software can overwrite the flag through a one-cycle write port. Such a write takes precedence over every hardware update in the same cycle. Activity on the pin that starts and ends between two strobes is never seen.

Top module: `xint_sampler`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `req_o` is 0.
- R2: The pin passes through two clock flops before it is sampled. A strobe in the clock cycle directly after the pin changes still sees the old pin value. A strobe two cycles after the change sees the new value.
- R3: In level mode (`edge_mode_i` = 0), each strobe loads `req_o` with the inverse of the synchronised pin: 1 for low, 0 for high.
- R4: Between strobes, with no write and no acknowledge, `req_o` keeps its value whatever the pin does.
- R5: In edge mode (`edge_mode_i` = 1), a strobe that samples low after the previous strobe sampled high sets `req_o` to 1.
- R6: In edge mode, a pin held low produces exactly one request: after the request is acknowledged, further low samples do not set it again.
- R7: In edge mode, `ack_i` clears `req_o` in the next cycle. When an edge is detected in the same cycle as `ack_i`, the set wins.
- R8: In level mode, `ack_i` has no effect on `req_o`.
- R9: After reset, edge mode needs a high sample before any low sample can count as an edge. A pin held low through reset raises no request.
- R10: When `sw_we_i` is 1, `req_o` takes `sw_wdata_i` in the next cycle, regardless of the strobe, the acknowledge and the mode.
- R11: A low pulse on the pin that begins and ends between two strobes leaves `req_o` unchanged, in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_n_i | input | 1 | External interrupt pin, active low, asynchronous |
| edge_mode_i | input | 1 | 0 = level detection, 1 = falling-edge detection |
| smp_stb_i | input | 1 | Machine-cycle sampling strobe, one clock wide |
| ack_i | input | 1 | Acknowledge pulse from the interrupt controller |
| sw_we_i | input | 1 | Software write enable for the flag |
| sw_wdata_i | input | 1 | Value written to the flag |
| req_o | output | 1 | Interrupt request flag |

## Verification
The bench holds the pin low through reset in edge mode. A design that armed its edge detector at reset would raise a request there that no high sample came before. It keeps the pin low after an acknowledge in edge mode, where a detector that compared the pin against a constant rather than the previous sample would request again and again. It also acknowledges in level mode, where a design that cleared the flag would drop a request that is still held. It places a strobe one and two cycles after a pin change and a two-cycle glitch between strobes, which catch a wrong synchroniser depth and sampling outside the strobe. Finally it lines up an edge with an acknowledge, and a software write with a strobe, to pin down the order of precedence.

// File: rtl/xint_pkg.sv
package xint_pkg;

    // Registered state of the flag core.
    typedef struct packed {
        logic flag;   // request flag seen by the controller
        logic armed;  // last strobe sampled the pin high
    } xint_state_t;

    localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_chain
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/xint_flag_core.sv
module xint_flag_core
    import xint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic edge_mode,
    input  logic smp_stb,
    input  logic ack,
    input  logic sw_we,
    input  logic sw_wdata,
    output logic flag
);
    xint_state_t st_d, st_q;
    logic        fall_seen;

    always_comb begin
        st_d      = st_q;
        fall_seen = smp_stb && st_q.armed && !pin_s;

        if (smp_stb) begin
            st_d.armed = pin_s;
        end

        if (!edge_mode) begin
            if (smp_stb) st_d.flag = !pin_s;
        end else begin
            if (fall_seen)  st_d.flag = 1'b1;
            else if (ack)   st_d.flag = 1'b0;
        end

        if (sw_we) st_d.flag = sw_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{flag: 1'b0, armed: 1'b0};
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/xint_sampler.sv
module xint_sampler #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    input  logic edge_mode_i,
    input  logic smp_stb_i,
    input  logic ack_i,
    input  logic sw_we_i,
    input  logic sw_wdata_i,
    output logic req_o
);
    logic pin_s;

    xint_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_n_i),
        .dout (pin_s)
    );

    xint_flag_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_s    (pin_s),
        .edge_mode(edge_mode_i),
        .smp_stb  (smp_stb_i),
        .ack      (ack_i),
        .sw_we    (sw_we_i),
        .sw_wdata (sw_wdata_i),
        .flag     (req_o)
    );
endmodule

// File: rtl/xint_sampler_chk.sv
module xint_sampler_chk (
    input logic clk,
    input logic rst_n,
    input logic pin_s,
    input logic edge_mode_i,
    input logic smp_stb_i,
    input logic ack_i,
    input logic sw_we_i,
    input logic sw_wdata_i,
    input logic req_o
);
    a_r1_reset_low: assert property (@(posedge clk)
        $rose(rst_n) |-> !req_o);

    a_r3_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb_i && !edge_mode_i && !sw_we_i |=> req_o == !$past(pin_s));

    a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb_i && !sw_we_i && !ack_i |=> $stable(req_o));

    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        edge_mode_i && ack_i && !smp_stb_i && !sw_we_i |=> !req_o);

    a_r8_level_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode_i && !smp_stb_i && !sw_we_i |=> $stable(req_o));

    a_r10_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we_i |=> req_o == $past(sw_wdata_i));
endmodule

bind xint_sampler xint_sampler_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_s      (pin_s),
    .edge_mode_i(edge_mode_i),
    .smp_stb_i  (smp_stb_i),
    .ack_i      (ack_i),
    .sw_we_i    (sw_we_i),
    .sw_wdata_i (sw_wdata_i),
    .req_o      (req_o)
);

// File: tb/xint_sampler_test.sv
module xint_sampler_test;
    localparam int CLK_PERIOD = 10;
    localparam int MCYC       = 12;
    localparam int WATCHDOG   = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_n = 1'b0;
    logic edge_mode = 1'b1;
    logic smp_stb = 1'b0;
    logic ack = 1'b0;
    logic sw_we = 1'b0;
    logic sw_wdata = 1'b0;
    logic req;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag   = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    xint_sampler uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_n_i    (pin_n),
        .edge_mode_i(edge_mode),
        .smp_stb_i  (smp_stb),
        .ack_i      (ack),
        .sw_we_i    (sw_we),
        .sw_wdata_i (sw_wdata),
        .req_o      (req)
    );

    // Behavioural reference: pin history queue plus flag and arming bits.
    bit hist[$];
    bit m_flag;
    bit m_armed;

    initial begin
        hist = '{1'b1, 1'b1};
        m_flag = 1'b0;
        m_armed = 1'b0;
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist = '{1'b1, 1'b1};
            m_flag = 1'b0;
            m_armed = 1'b0;
        end else begin
            bit seen;
            bit nf;
            seen = hist[$];
            nf = m_flag;
            if (edge_mode == 1'b0) begin
                if (smp_stb) nf = !seen;
            end else if (smp_stb && m_armed && !seen) begin
                nf = 1'b1;
            end else if (ack) begin
                nf = 1'b0;
            end
            if (sw_we) nf = sw_wdata;
            if (smp_stb) m_armed = seen;
            m_flag = nf;
            hist.push_front(pin_n);
            void'(hist.pop_back());
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (req !== m_flag) begin
                n_bad++;
                $display("FAIL %s model compare at %0t: actual=%0b expected=%0b",
                         tag, $time, req, m_flag);
            end
        end
    end

    task automatic check(input string rq, input logic expv);
        n_cmp++;
        if (req !== expv) begin
            n_bad++;
            $display("FAIL %s directed check at %0t: actual=%0b expected=%0b",
                     rq, $time, req, expv);
        end
    endtask

    task automatic cyc(input bit stb);
        smp_stb = stb;
        @(negedge clk);
        smp_stb = 1'b0;
        ack = 1'b0;
        sw_we = 1'b0;
    endtask

    // One machine cycle: eleven quiet clocks, then a strobe.
    task automatic mcycles(input int n);
        for (int i = 0; i < n * MCYC; i++) cyc((i % MCYC) == MCYC - 1);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_bad++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state, edge mode, pin low
        repeat (3) @(negedge clk);
        check("R1", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 1'b0);

        // R9: low pin held through reset is not an edge
        tag = "R9";
        mcycles(3);
        check("R9", 1'b0);

        // R5: high then low sample sets the flag
        tag = "R5";
        pin_n = 1'b1; mcycles(1);
        check("R5", 1'b0);
        pin_n = 1'b0; mcycles(1);
        check("R5", 1'b1);

        // R7 / R6: ack clears, held low does not re-trigger
        tag = "R7";
        ack = 1'b1; cyc(1'b0);
        check("R7", 1'b0);
        tag = "R6";
        mcycles(3);
        check("R6", 1'b0);

        // R7: edge and ack in the same cycle, set wins
        tag = "R7";
        pin_n = 1'b1; mcycles(1);
        pin_n = 1'b0;
        for (int i = 0; i < MCYC - 1; i++) cyc(1'b0);
        ack = 1'b1; cyc(1'b1);
        check("R7", 1'b1);
        ack = 1'b1; cyc(1'b0);
        check("R7", 1'b0);

        // R11: glitch between strobes in edge mode
        tag = "R11";
        pin_n = 1'b1; mcycles(1);
        for (int i = 0; i < MCYC; i++) begin
            pin_n = !(i == 2 || i == 3);
            cyc(i == MCYC - 1);
        end
        check("R11", 1'b0);

        // R3: level mode follows the pin
        tag = "R3";
        edge_mode = 1'b0;
        pin_n = 1'b0; mcycles(1);
        check("R3", 1'b1);

        // R8: ack ignored in level mode
        tag = "R8";
        ack = 1'b1; cyc(1'b0);
        check("R8", 1'b1);
        mcycles(1);
        check("R8", 1'b1);

        // R4: pin change without strobe holds the flag
        tag = "R4";
        pin_n = 1'b1;
        for (int i = 0; i < 6; i++) cyc(1'b0);
        check("R4", 1'b1);
        for (int i = 0; i < 6; i++) cyc(i == 5);
        check("R3", 1'b0);

        // R2: two-stage synchronisation latency
        tag = "R2";
        pin_n = 1'b0;
        cyc(1'b1);
        check("R2", 1'b0);
        cyc(1'b0);
        cyc(1'b1);
        check("R2", 1'b1);

        // R11: glitch between strobes in level mode
        tag = "R11";
        pin_n = 1'b1; mcycles(1);
        check("R3", 1'b0);
        for (int i = 0; i < MCYC; i++) begin
            pin_n = !(i == 3 || i == 4);
            cyc(i == MCYC - 1);
        end
        check("R11", 1'b0);

        // R10: software write beats strobe and ack
        tag = "R10";
        sw_we = 1'b1; sw_wdata = 1'b1;
        for (int i = 0; i < MCYC - 1; i++) cyc(1'b0);
        sw_we = 1'b1; sw_wdata = 1'b1; cyc(1'b1);
        check("R10", 1'b1);
        edge_mode = 1'b1;
        sw_we = 1'b1; sw_wdata = 1'b0; ack = 1'b0;
        cyc(1'b0);
        check("R10", 1'b0);
        pin_n = 1'b1; mcycles(1);
        pin_n = 1'b0;
        for (int i = 0; i < MCYC - 1; i++) cyc(1'b0);
        sw_we = 1'b1; sw_wdata = 1'b0; cyc(1'b1);
        check("R10", 1'b0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule